// File: doc/BRIEF.md
# Gated-Window Frequency Meter

This block measures the rate of an asynchronous input by counting its rising edges during a sample window of programmable length. The input is first brought into the system clock domain and reduced to one-cycle edge events. Those events pass only while the window gate is open, and each one advances a chain of cascaded decimal digits. The reading is therefore the number of rising edges that arrived during the window. Dividing that reading by the window length gives the frequency. With a window of one second's worth of system clocks, the reading is the frequency in Hz.

Each measurement cycle runs in a fixed order: the gate phase lasts the configured number of clocks, a latch phase of one cycle copies the digits into a holding register, and a clear phase of one cycle empties the digit chain. The next gate phase then begins. The held digits stay stable between latches, so a display can read them at any time. A one-cycle valid strobe marks each new reading. If the most significant digit wraps during a window, the reading is flagged as overflowed.

Top module: `freq_meter`

## Requirements
- R1: While reset is asserted and after its release until the first latch, digits_o is all zero and ovf_o and valid_o are 0.
- R2: With W = max(win_len_i, 1), one measurement cycle lasts W + 2 clocks: W gate clocks, one latch clock and one clear clock. valid_o is high for exactly one clock per cycle, so successive strobes are W + 2 clocks apart.
- R3: Let c be a clock cycle in which valid_o is high. A rise of sig_i that is first sampled by the clock edge ending cycle c + j is counted in the next reading when 0 <= j <= W - 2. When j = W - 1 or j = W, the rise lands in the latch or clear clock and is counted in no reading.
- R4: Only low-to-high transitions count. A level held high across windows counts once, and falling edges count nothing.
- R5: digits_o is packed BCD. Digit i sits in bits [4i+3:4i] and has weight 10^i, and every digit is in the range 0 to 9. For K counted rises, the reading is K mod 10^NUM_DIGITS.
- R6: ovf_o is 1 with a reading exactly when K >= 10^NUM_DIGITS during that window.
- R7: digits_o and ovf_o change only in the clock where valid_o goes high, and hold their values at all other times.
- R8: The digit chain and the overflow state are cleared every cycle, so each reading depends only on its own window.
- R9: A win_len_i of 0 behaves as a window of one clock. The cycle is then 3 clocks, and since W - 2 < 0 no rise is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Signal being measured, asynchronous to clk_i |
| win_len_i | input | WIN_W | Gate window length in clocks |
| digits_o | output | 4*NUM_DIGITS | Held reading, packed BCD, least significant digit in the low bits |
| ovf_o | output | 1 | The held reading overflowed the digit chain |
| valid_o | output | 1 | One-clock strobe when a new reading is latched |

## Verification
The hardest situations to reach from the ports are edges whose synchronized detection falls exactly on the last gate clock, on the latch clock or on the clear clock. Overflow is also hard to reach, because it needs more than a hundred rises inside one window. The stimulus aligns every rise to the valid strobe and counts offsets in whole clocks, which places single rises at W - 2, W - 1 and W. A long window then carries a sweep of 0 to 105 rises, which crosses the digit carries and the wrap point of a two-digit chain.

// File: rtl/freq_pkg.sv
package freq_pkg;
  typedef enum logic [1:0] {
    PH_GATE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_CLEAR = 2'd2
  } phase_e;

  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/freq_sig_edge.sv
module freq_sig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sig_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/freq_decade.sv
module freq_decade
  import freq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t val_o,
  output logic carry_o
);
  bcd_t val_q;

  assign carry_o = inc_i && (val_q == BCD_MAX);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (clr_i)   val_q <= '0;
    else if (inc_i)   val_q <= carry_o ? '0 : val_q + 4'd1;
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q <= BCD_MAX); // R5
  AST_DIGIT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && val_q == BCD_MAX) |=> (val_q == '0)); // R5
endmodule

// File: rtl/freq_decade_chain.sv
module freq_decade_chain
  import freq_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    ev_i,
  output logic [4*NUM_DIGITS-1:0] count_o,
  output logic                    wrap_o
);
  logic [NUM_DIGITS:0] inc;

  assign inc[0] = ev_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
    bcd_t val;
    freq_decade u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .inc_i  (inc[i]),
      .val_o  (val),
      .carry_o(inc[i+1])
    );
    assign count_o[4*i +: 4] = val;
  end

  assign wrap_o = inc[NUM_DIGITS];
endmodule

// File: rtl/freq_window_seq.sv
module freq_window_seq
  import freq_pkg::*;
#(
  parameter int WIN_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_len_i,
  output phase_e           phase_o
);
  localparam logic [WIN_W-1:0] WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

  phase_e           ph_q;
  logic [WIN_W-1:0] wcnt_q;
  logic [WIN_W-1:0] last;

  assign last    = (win_len_i == '0) ? '0 : win_len_i - WIN_ONE;
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_GATE;
      wcnt_q <= '0;
    end else begin
      case (ph_q)
        PH_GATE: begin
          // >= keeps a window that was shortened mid-gate bounded
          if (wcnt_q >= last) begin
            ph_q   <= PH_LATCH;
            wcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + WIN_ONE;
          end
        end
        PH_LATCH: ph_q <= PH_CLEAR;
        PH_CLEAR: ph_q <= PH_GATE;
        default:  ph_q <= PH_GATE;
      endcase
    end
  end

  AST_LATCH_TO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_LATCH |=> ph_q == PH_CLEAR); // R2
  AST_CLEAR_TO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_CLEAR |=> ph_q == PH_GATE); // R2
  AST_IDLE_WCNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != PH_GATE |-> wcnt_q == '0); // R2
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int WIN_W       = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sig_i,
  input  logic [WIN_W-1:0]        win_len_i,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic                    ovf_o,
  output logic                    valid_o
);
  localparam int DW = 4 * NUM_DIGITS;

  phase_e          phase;
  logic            rise;
  logic            count_ev;
  logic            wrap;
  logic [DW-1:0]   count;
  logic            ovf_q;
  logic [DW-1:0]   hold_q;
  logic            hold_ovf_q;
  logic            valid_q;

  freq_sig_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .rise_o(rise)
  );

  freq_window_seq #(.WIN_W(WIN_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_len_i(win_len_i),
    .phase_o  (phase)
  );

  assign count_ev = (phase == PH_GATE) && rise;

  freq_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase == PH_CLEAR),
    .ev_i   (count_ev),
    .count_o(count),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= 1'b0;
    else if (phase == PH_CLEAR)  ovf_q <= 1'b0;
    else if (wrap)               ovf_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_ovf_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= (phase == PH_LATCH);
      if (phase == PH_LATCH) begin
        hold_q     <= count;
        hold_ovf_q <= ovf_q;
      end
    end
  end

  assign digits_o = hold_q;
  assign ovf_o    = hold_ovf_q;
  assign valid_o  = valid_q;

  AST_NO_COUNT_IN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_LATCH |=> $stable(count)); // R3
  AST_IDLE_GATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_GATE && !rise) |=> $stable(count)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_CLEAR |=> (count == '0 && !ovf_q)); // R8
  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_q); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(digits_o) && $stable(ovf_o))); // R7
endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  localparam int ND   = 2;
  localparam int WW   = 16;
  localparam int DW   = 4 * ND;
  localparam int MODV = 100;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sig_i = 1'b0;
  logic [WW-1:0] win_len_i = 16'd8;
  logic [DW-1:0] digits_o;
  logic          ovf_o;
  logic          valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  freq_meter #(.NUM_DIGITS(ND), .WIN_W(WW)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .sig_i    (sig_i),
    .win_len_i(win_len_i),
    .digits_o (digits_o),
    .ovf_o    (ovf_o),
    .valid_o  (valid_o)
  );

  function automatic logic [DW-1:0] to_bcd(int v);
    logic [DW-1:0] r;
    r = '0;
    for (int d = 0; d < ND; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!valid_o);
  endtask

  // Starts and ends on a negedge where valid_o is high.
  task automatic drive_window(int win, int k, int extra, bit level);
    int            eff;
    logic [DW-1:0] held;
    logic          held_ovf;
    bit            moved;
    eff      = (win == 0) ? 1 : win;
    held     = digits_o;
    held_ovf = ovf_o;
    moved    = 1'b0;
    win_len_i = WW'(win);
    for (int j = 0; j <= eff; j++) begin
      sig_i = level | ((j % 2 == 0) && (j < 2 * k)) | (j == extra);
      @(negedge clk);
      if (j == 0) check(valid_o == 1'b0, "R2 strobe width", int'(valid_o), 0);
      if (digits_o !== held || ovf_o !== held_ovf) moved = 1'b1;
    end
    sig_i = level;
    while (!valid_o) begin
      @(negedge clk);
      if (!valid_o && (digits_o !== held || ovf_o !== held_ovf)) moved = 1'b1;
    end
    check(!moved, "R7 held value stable", int'(moved), 0);
  endtask

  task automatic check_reading(int k, string tag);
    check(digits_o == to_bcd(k % MODV), tag, int'(digits_o), int'(to_bcd(k % MODV)));
    check(ovf_o == (k >= MODV), {tag, " ovf (R6)"}, int'(ovf_o), int'(k >= MODV));
  endtask

  task automatic measure_period(int win, string tag);
    int cnt;
    int exp;
    cnt = 0;
    exp = ((win == 0) ? 1 : win) + 2;
    win_len_i = WW'(win);
    do begin
      @(negedge clk);
      cnt++;
    end while (!valid_o);
    check(cnt == exp, tag, cnt, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(digits_o == '0, "R1 reset digits", int'(digits_o), 0);
    check(ovf_o == 1'b0, "R1 reset ovf", int'(ovf_o), 0);
    check(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(digits_o == '0 && valid_o == 1'b0, "R1 after release", int'(digits_o), 0);
    wait_valid();

    // R5/R6: sweep count 0..105 in a long window
    for (int k = 0; k <= 105; k++) begin
      drive_window(220, k, -1, 1'b0);
      check_reading(k, "R5 sweep");
    end
    // R8: overflowed window followed by a small one
    drive_window(220, 3, -1, 1'b0);
    check_reading(3, "R8 fresh window");

    // R3: boundary offsets with W = 6
    drive_window(6, 0, 0, 1'b0);
    check_reading(1, "R3 rise at j=0");
    drive_window(6, 0, 4, 1'b0);
    check_reading(1, "R3 rise at j=W-2");
    drive_window(6, 0, 5, 1'b0);
    check_reading(0, "R3 rise at j=W-1 dropped");
    drive_window(6, 0, 6, 1'b0);
    check_reading(0, "R3 rise at j=W dropped");
    drive_window(6, 0, -1, 1'b0);
    check_reading(0, "R3 dropped rise absent next window");
    drive_window(6, 2, 5, 1'b0);
    check_reading(2, "R3 two counted one dropped");

    // R4: level behaviour
    drive_window(8, 0, -1, 1'b1);
    check_reading(1, "R4 level rise counts once");
    drive_window(8, 0, -1, 1'b1);
    check_reading(0, "R4 steady high counts nothing");
    drive_window(8, 0, -1, 1'b0);
    check_reading(0, "R4 falling edge counts nothing");

    // R2: cycle length
    measure_period(1, "R2 period W=1");
    measure_period(2, "R2 period W=2");
    measure_period(5, "R2 period W=5");
    measure_period(9, "R2 period W=9");

    // R9: zero length window
    measure_period(0, "R9 period W=0");
    drive_window(0, 1, -1, 1'b0);
    check_reading(0, "R9 no count with W=0");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule